// File: doc/BRIEF.md
# Character-Synchronous Serial Receiver with Sync Hunt

This block receives a character-oriented synchronous serial stream. It samples the serial data line on each rising edge of the receive clock. After a hunt command it searches the stream one bit at a time for a programmed sync character, or for a pair of them in sequence. When the hunt succeeds it raises a sync-detect indication and assembles every later group of bits into a character. In external mode a sync input ends the hunt, and no characters are compared.

Finished characters go to a small CPU register port. Single-cycle read and write strobes are qualified by a control/data select. A receive-ready output shows that an unread character is waiting. A status register reports receive-ready, parity error, overrun and sync-detect. Character length, parity, sync mode and the two sync characters are static configuration inputs.

Top module: `sync_hunt_rx`

## Requirements
- R1: After reset, `rxrdy` is 0, `syndet_out` is 0, every status bit reads 0, and the receiver is disabled and in hunt mode.
- R2: A command write (`wr`=1, `cd`=1) loads the receiver enable from `din[0]`. Setting `din[1]` enters hunt mode. While the block hunts it delivers no character. While the enable is 0, receive-clock edges have no effect.
- R3: In internal mode the hunt compares the most recent frame-length bits against the first sync character after every sampled bit. The frame is the data bits, LSB first, followed by the parity bit when parity is on. On a match the hunt ends, status bit 3 and `syndet_out` go to 1, and the next sampled bit is data bit 0.
- R4: With `cfg_two_sync`=1, the frame that immediately follows the first sync character must equal the second sync character, or the hunt goes back to looking for the first one. `syndet` rises only after both have matched.
- R5: With `cfg_ext_sync`=1, the serial pattern is ignored during the hunt. The hunt ends at the first sampled bit where `syndet_in` is 1. That bit is discarded, status bit 3 is set, and `syndet_out` stays 0.
- R6: `cfg_len` codes 0 to 3 select 5 to 8 data bits. A character is read from `dout` with `cd`=0, right-aligned, with its upper bits 0.
- R7: When `cfg_par_en`=1 the bit after the data bits is parity. The parity is even when `cfg_par_odd`=0 and odd when it is 1. A mismatch sets status bit 1.
- R8: After synchronisation every character is delivered, sync patterns included. Each one sets `rxrdy` (status bit 0), and a data read clears it.
- R9: A character that completes while `rxrdy` is 1 replaces the unread one and sets status bit 2. That bit stays set.
- R10: A command write with `din[2]`=1 clears the parity-error and overrun bits.
- R11: A status read (`rd`=1, `cd`=1) or entering hunt mode clears the sync-detect status. `syndet_out` follows that status in internal mode.
- R12: When a data read falls in the same cycle as a character completing, the read returns the previous character, `rxrdy` stays 1, and no overrun is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxc | input | 1 | Receive clock, synchronous to clk; data is sampled on its rising edge |
| rxd | input | 1 | Serial receive data |
| syndet_in | input | 1 | External sync input, used when cfg_ext_sync=1 |
| syndet_out | output | 1 | Sync-detect indication, internal mode only |
| rd | input | 1 | Read strobe, one clk cycle |
| wr | input | 1 | Write strobe, one clk cycle |
| cd | input | 1 | 1 selects status/command, 0 selects data |
| din | input | 8 | Command write data |
| dout | output | 8 | Status or received character |
| rxrdy | output | 1 | Unread character available |
| cfg_len | input | 2 | Data length code, 0 gives 5 bits and 3 gives 8 bits |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | Odd parity when 1 |
| cfg_ext_sync | input | 1 | External sync mode |
| cfg_two_sync | input | 1 | Two sync characters required |
| cfg_sync1 | input | 8 | First sync character |
| cfg_sync2 | input | 8 | Second sync character |

## Verification
A data read and the completion of the next character can land in the same clk cycle. This decides whether a character is counted as lost. The bench provokes it by raising the data read together with the receive-clock edge of a character's last bit. It then checks four things: the read returned the older character, `rxrdy` is still 1, the overrun bit is 0, and the next data read returns the newer character. The same path is checked the other way round by letting two characters complete with no read between them. That case must set the overrun bit.

// File: rtl/sync_hunt_rx_pkg.sv
package sync_hunt_rx_pkg;
   typedef enum logic [1:0] {
      ST_HUNT1  = 2'd0,
      ST_HUNT2  = 2'd1,
      ST_LOCKED = 2'd2
   } rx_state_e;

   localparam int CMD_EN   = 0;
   localparam int CMD_HUNT = 1;
   localparam int CMD_ERR  = 2;

   localparam int STB_RDY  = 0;
   localparam int STB_PE   = 1;
   localparam int STB_OE   = 2;
   localparam int STB_SYN  = 3;
endpackage

// File: rtl/sync_hunt_rx_shift.sv
module sync_hunt_rx_shift #(
   parameter int FRAME_W = 9
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rxc,
   input  logic               rxd,
   input  logic               enable,
   input  logic               clear,
   output logic               bit_tick,
   output logic [FRAME_W-1:0] win_next
);
   logic               rxc_q;
   logic [FRAME_W-1:0] win_q;

   assign bit_tick = rxc & ~rxc_q & enable;
   assign win_next = {rxd, win_q[FRAME_W-1:1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rxc_q <= 1'b0;
         win_q <= '0;
      end else begin
         rxc_q <= rxc;
         if (clear)
            win_q <= '0;
         else if (bit_tick)
            win_q <= win_next;
      end
   end
endmodule

// File: rtl/sync_hunt_rx_seq.sv
module sync_hunt_rx_seq
   import sync_hunt_rx_pkg::*;
#(
   parameter int MIN_LEN    = 5,
   parameter int MAX_LEN    = 8,
   parameter int LEN_CODE_W = 2,
   parameter int FRAME_W    = MAX_LEN + 1,
   parameter int CNT_W      = $clog2(FRAME_W + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bit_tick,
   input  logic [FRAME_W-1:0]    win_next,
   input  logic [LEN_CODE_W-1:0] len_code,
   input  logic                  par_en,
   input  logic                  par_odd,
   input  logic                  ext_mode,
   input  logic                  two_sync,
   input  logic                  ext_sync_in,
   input  logic [MAX_LEN-1:0]    sync1,
   input  logic [MAX_LEN-1:0]    sync2,
   input  logic                  hunt_req,
   output logic                  hunting,
   output logic                  sync_found,
   output logic                  done,
   output logic [MAX_LEN-1:0]    rx_data,
   output logic                  par_bad
);
   rx_state_e          state_q, state_d;
   logic [CNT_W-1:0]   cnt_q, cnt_d;
   logic [CNT_W-1:0]   dlen, flen;
   logic [MAX_LEN-1:0] mask;
   logic [FRAME_W-1:0] aligned, exp1, exp2;
   logic               last_bit;

   assign dlen = CNT_W'(MIN_LEN) + CNT_W'(len_code);
   assign flen = dlen + CNT_W'(par_en);

   for (genvar i = 0; i < MAX_LEN; i++) begin : g_mask
      assign mask[i] = (CNT_W'(i) < dlen);
   end

   function automatic logic [FRAME_W-1:0] frame_of(
      input logic [MAX_LEN-1:0] ch, input logic [MAX_LEN-1:0] m,
      input logic [CNT_W-1:0] dl, input logic pen, input logic odd);
      logic [MAX_LEN-1:0] d;
      logic [FRAME_W-1:0] f;
      d = ch & m;
      f = FRAME_W'(d);
      if (pen) f[dl] = (^d) ^ odd;
      return f;
   endfunction

   assign aligned  = win_next >> (CNT_W'(FRAME_W) - flen);
   assign exp1     = frame_of(sync1, mask, dlen, par_en, par_odd);
   assign exp2     = frame_of(sync2, mask, dlen, par_en, par_odd);
   assign last_bit = (cnt_q == flen - CNT_W'(1));
   assign rx_data  = aligned[MAX_LEN-1:0] & mask;
   assign par_bad  = par_en & (aligned[dlen] != ((^rx_data) ^ par_odd));
   assign hunting  = (state_q != ST_LOCKED);

   always_comb begin
      state_d    = state_q;
      cnt_d      = cnt_q;
      done       = 1'b0;
      sync_found = 1'b0;
      if (hunt_req) begin
         state_d = ST_HUNT1;
         cnt_d   = '0;
      end else if (bit_tick) begin
         unique case (state_q)
            ST_HUNT1: begin
               cnt_d = '0;
               if (ext_mode) begin
                  if (ext_sync_in) begin
                     state_d    = ST_LOCKED;
                     sync_found = 1'b1;
                  end
               end else if (aligned == exp1) begin
                  if (two_sync) begin
                     state_d = ST_HUNT2;
                  end else begin
                     state_d    = ST_LOCKED;
                     sync_found = 1'b1;
                  end
               end
            end
            ST_HUNT2: begin
               if (last_bit) begin
                  cnt_d = '0;
                  if (aligned == exp2) begin
                     state_d    = ST_LOCKED;
                     sync_found = 1'b1;
                  end else begin
                     state_d = ST_HUNT1;
                  end
               end else begin
                  cnt_d = cnt_q + CNT_W'(1);
               end
            end
            ST_LOCKED: begin
               if (last_bit) begin
                  done  = 1'b1;
                  cnt_d = '0;
               end else begin
                  cnt_d = cnt_q + CNT_W'(1);
               end
            end
            default: state_d = ST_HUNT1;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_HUNT1;
         cnt_q   <= '0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
      end
   end
endmodule

// File: rtl/sync_hunt_rx_regs.sv
module sync_hunt_rx_regs
   import sync_hunt_rx_pkg::*;
#(
   parameter int MAX_LEN = 8,
   parameter int BUS_W   = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rd,
   input  logic               wr,
   input  logic               cd,
   input  logic [BUS_W-1:0]   din,
   input  logic               done,
   input  logic [MAX_LEN-1:0] rx_data,
   input  logic               par_bad,
   input  logic               sync_found,
   input  logic               ext_mode,
   output logic [BUS_W-1:0]   dout,
   output logic               rxrdy,
   output logic               rx_en,
   output logic               hunt_req,
   output logic               syndet_out,
   output logic               st_oe,
   output logic               st_syn
);
   logic               cmd_wr, err_clr, data_rd, stat_rd, st_pe;
   logic [MAX_LEN-1:0] data_q;
   logic [BUS_W-1:0]   status;

   assign cmd_wr   = wr & cd;
   assign hunt_req = cmd_wr & din[CMD_HUNT];
   assign err_clr  = cmd_wr & din[CMD_ERR];
   assign data_rd  = rd & ~cd;
   assign stat_rd  = rd & cd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_en  <= 1'b0;
         data_q <= '0;
         rxrdy  <= 1'b0;
         st_pe  <= 1'b0;
         st_oe  <= 1'b0;
         st_syn <= 1'b0;
      end else begin
         if (cmd_wr) rx_en <= din[CMD_EN];
         if (done) data_q <= rx_data;

         if (done) rxrdy <= 1'b1;
         else if (data_rd) rxrdy <= 1'b0;

         if (done && rxrdy && !data_rd) st_oe <= 1'b1;
         else if (err_clr) st_oe <= 1'b0;

         if (done && par_bad) st_pe <= 1'b1;
         else if (err_clr) st_pe <= 1'b0;

         if (sync_found) st_syn <= 1'b1;
         else if (stat_rd || hunt_req) st_syn <= 1'b0;
      end
   end

   always_comb begin
      status          = '0;
      status[STB_RDY] = rxrdy;
      status[STB_PE]  = st_pe;
      status[STB_OE]  = st_oe;
      status[STB_SYN] = st_syn;
   end

   assign dout       = cd ? status : BUS_W'(data_q);
   assign syndet_out = st_syn & ~ext_mode;
endmodule

// File: rtl/sync_hunt_rx.sv
module sync_hunt_rx #(
   parameter int MIN_LEN    = 5,
   parameter int MAX_LEN    = 8,
   parameter int BUS_W      = 8,
   parameter int LEN_CODE_W = $clog2(MAX_LEN - MIN_LEN + 1),
   parameter int FRAME_W    = MAX_LEN + 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  rxc,
   input  logic                  rxd,
   input  logic                  syndet_in,
   output logic                  syndet_out,
   input  logic                  rd,
   input  logic                  wr,
   input  logic                  cd,
   input  logic [BUS_W-1:0]      din,
   output logic [BUS_W-1:0]      dout,
   output logic                  rxrdy,
   input  logic [LEN_CODE_W-1:0] cfg_len,
   input  logic                  cfg_par_en,
   input  logic                  cfg_par_odd,
   input  logic                  cfg_ext_sync,
   input  logic                  cfg_two_sync,
   input  logic [MAX_LEN-1:0]    cfg_sync1,
   input  logic [MAX_LEN-1:0]    cfg_sync2
);
   if (MIN_LEN < 1 || MAX_LEN < MIN_LEN) begin : g_bad_len
      $error("sync_hunt_rx: character length range is invalid");
   end
   if (BUS_W < MAX_LEN || BUS_W < 4) begin : g_bad_bus
      $error("sync_hunt_rx: bus narrower than character or status");
   end
   if (FRAME_W != MAX_LEN + 1) begin : g_bad_frame
      $error("sync_hunt_rx: frame width must be MAX_LEN + 1");
   end

   logic               bit_tick, hunt_req, rx_en, hunting, sync_found, done, par_bad;
   logic               st_oe, st_syn;
   logic [FRAME_W-1:0] win_next;
   logic [MAX_LEN-1:0] rx_data;

   sync_hunt_rx_shift #(.FRAME_W(FRAME_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .rxc(rxc), .rxd(rxd), .enable(rx_en),
      .clear(hunt_req), .bit_tick(bit_tick), .win_next(win_next)
   );

   sync_hunt_rx_seq #(
      .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN), .LEN_CODE_W(LEN_CODE_W), .FRAME_W(FRAME_W)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .win_next(win_next),
      .len_code(cfg_len), .par_en(cfg_par_en), .par_odd(cfg_par_odd),
      .ext_mode(cfg_ext_sync), .two_sync(cfg_two_sync), .ext_sync_in(syndet_in),
      .sync1(cfg_sync1), .sync2(cfg_sync2), .hunt_req(hunt_req), .hunting(hunting),
      .sync_found(sync_found), .done(done), .rx_data(rx_data), .par_bad(par_bad)
   );

   sync_hunt_rx_regs #(.MAX_LEN(MAX_LEN), .BUS_W(BUS_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .rd(rd), .wr(wr), .cd(cd), .din(din),
      .done(done), .rx_data(rx_data), .par_bad(par_bad), .sync_found(sync_found),
      .ext_mode(cfg_ext_sync), .dout(dout), .rxrdy(rxrdy), .rx_en(rx_en),
      .hunt_req(hunt_req), .syndet_out(syndet_out), .st_oe(st_oe), .st_syn(st_syn)
   );
endmodule

// File: rtl/sync_hunt_rx_chk.sv
module sync_hunt_rx_chk (
   input logic clk,
   input logic rst_n,
   input logic rd,
   input logic wr,
   input logic cd,
   input logic err_bit,
   input logic rxrdy,
   input logic hunting,
   input logic done,
   input logic st_oe,
   input logic st_syn,
   input logic ext_mode,
   input logic syndet_out
);
   AST_HUNT_NO_RDY: assert property (@(posedge clk) disable iff (!rst_n)
      hunting && !rxrdy |=> !rxrdy); // R2
   AST_LEAVE_HUNT_SYN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hunting) |-> st_syn); // R3
   AST_EXT_PIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      ext_mode |-> !syndet_out); // R5
   AST_READ_CLEARS_RDY: assert property (@(posedge clk) disable iff (!rst_n)
      rd && !cd && !done |=> !rxrdy); // R8
   AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
      done && rxrdy && !(rd && !cd) |=> st_oe); // R9
   AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      st_oe && !(wr && cd && err_bit) |=> st_oe); // R9
   AST_COLLIDE_NO_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
      done && rd && !cd && !st_oe |=> rxrdy && !st_oe); // R12
endmodule

bind sync_hunt_rx sync_hunt_rx_chk u_chk (
   .clk(clk), .rst_n(rst_n), .rd(rd), .wr(wr), .cd(cd), .err_bit(din[2]),
   .rxrdy(rxrdy), .hunting(hunting), .done(done), .st_oe(st_oe),
   .st_syn(st_syn), .ext_mode(cfg_ext_sync), .syndet_out(syndet_out)
);

// File: tb/sync_hunt_rx_tb.sv
module sync_hunt_rx_tb;
   logic       clk = 1'b0, rst_n = 1'b0;
   logic       rxc = 1'b0, rxd = 1'b0, syndet_in = 1'b0, syndet_out;
   logic       rd = 1'b0, wr = 1'b0, cd = 1'b0, rxrdy;
   logic [7:0] din = '0, dout;
   logic [1:0] cfg_len = 2'd3;
   logic       cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_ext_sync = 1'b0, cfg_two_sync = 1'b0;
   logic [7:0] cfg_sync1 = 8'hA7, cfg_sync2 = 8'h6D;
   int         n_chk = 0, n_fail = 0;

   always #2 clk = ~clk;

   sync_hunt_rx u_dut (
      .clk(clk), .rst_n(rst_n), .rxc(rxc), .rxd(rxd), .syndet_in(syndet_in),
      .syndet_out(syndet_out), .rd(rd), .wr(wr), .cd(cd), .din(din), .dout(dout),
      .rxrdy(rxrdy), .cfg_len(cfg_len), .cfg_par_en(cfg_par_en),
      .cfg_par_odd(cfg_par_odd), .cfg_ext_sync(cfg_ext_sync),
      .cfg_two_sync(cfg_two_sync), .cfg_sync1(cfg_sync1), .cfg_sync2(cfg_sync2)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic bit par_of(input logic [7:0] v, input int dl, input bit odd);
      bit p = odd;
      for (int i = 0; i < dl; i++) p ^= v[i];
      return p;
   endfunction

   task automatic send_bit(input logic b);
      rxd = b; @(negedge clk); rxc = 1'b1; @(negedge clk); rxc = 1'b0; @(negedge clk);
   endtask

   task automatic send_char(input logic [7:0] v, input bit flip);
      int dl = 5 + int'(cfg_len);
      for (int i = 0; i < dl; i++) send_bit(v[i]);
      if (cfg_par_en) send_bit(par_of(v, dl, cfg_par_odd) ^ flip);
   endtask

   task automatic wr_cmd(input logic [7:0] v);
      cd = 1'b1; din = v; wr = 1'b1; @(negedge clk); wr = 1'b0;
   endtask

   task automatic rd_reg(input bit c, output logic [7:0] v);
      cd = c; rd = 1'b1; #1 v = dout; @(negedge clk); rd = 1'b0;
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      finish_run();
   end

   initial begin
      logic [7:0] s, d, exp_d, a, b;
      int dl;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      cd = 1'b1; #1;
      chk(rxrdy == 0 && syndet_out == 0, "R1 reset outputs", {rxrdy, syndet_out}, 0);
      chk(dout == 8'h00, "R1 reset status", dout, 0);

      // R2: hunt without enable ignores the stream
      wr_cmd(8'h02);
      send_char(cfg_sync1, 0);
      chk(syndet_out == 0, "R2 disabled receiver ignored sync", syndet_out, 0);

      // Sweep: every length, parity mode and one/two sync characters
      for (int ln = 0; ln < 4; ln++)
         for (int pm = 0; pm < 3; pm++)
            for (int ts = 0; ts < 2; ts++) begin
               cfg_len = 2'(ln); cfg_par_en = (pm != 0); cfg_par_odd = (pm == 2);
               cfg_two_sync = ts[0]; dl = 5 + ln;
               wr_cmd(8'h07);
               for (int z = 0; z < 3 + ln; z++) send_bit(1'b0);
               chk(rxrdy == 0 && syndet_out == 0, "R2 hunting delivers nothing", rxrdy, 0);
               send_char(cfg_sync1, 0);
               if (ts) begin
                  chk(syndet_out == 0, "R4 first sync alone not enough", syndet_out, 0);
                  send_char(cfg_sync2, 0);
               end
               chk(syndet_out == 1, ts ? "R4 two sync found" : "R3 sync found", syndet_out, 1);
               rd_reg(1, s);
               chk(s[3] == 1, "R3 syndet status set", s, 8'h08);
               rd_reg(1, s);
               chk(s[3] == 0 && syndet_out == 0, "R11 status read clears syndet", s, 0);
               for (int k = 0; k < 3; k++) begin
                  d = (k == 2) ? cfg_sync1 : 8'(k * 53 + ln * 29 + pm * 7 + ts * 3 + 1);
                  exp_d = d & 8'((1 << dl) - 1);
                  send_char(d, 0);
                  chk(rxrdy == 1, "R8 character raises rxrdy", rxrdy, 1);
                  rd_reg(0, s);
                  chk(s == exp_d, "R6 received data", s, exp_d);
                  chk(rxrdy == 0, "R8 data read clears rxrdy", rxrdy, 0);
               end
               rd_reg(1, s);
               chk(s == 8'h00, "R7 good parity no error", s, 0);
            end

      // R4: wrong second sync falls back to hunting
      cfg_len = 2'd3; cfg_par_en = 1'b1; cfg_par_odd = 1'b0; cfg_two_sync = 1'b1;
      wr_cmd(8'h03);
      send_char(cfg_sync1, 0);
      send_char(8'h00, 0);
      send_char(8'h5A, 0);
      chk(syndet_out == 0 && rxrdy == 0, "R4 mismatch keeps hunting", syndet_out, 0);
      send_char(cfg_sync1, 0);
      send_char(cfg_sync2, 0);
      chk(syndet_out == 1, "R4 resync after mismatch", syndet_out, 1);

      // R11: hunt re-entry clears syndet
      wr_cmd(8'h03);
      rd_reg(1, s);
      chk(s[3] == 0 && syndet_out == 0, "R11 hunt clears syndet", s, 0);

      // R7/R10: parity errors in both senses, then error reset
      cfg_two_sync = 1'b0;
      for (int od = 0; od < 2; od++) begin
         cfg_par_odd = od[0];
         wr_cmd(8'h07);
         send_char(cfg_sync1, 0);
         send_char(8'h3C, 1);
         rd_reg(1, s);
         chk(s[1] == 1, "R7 parity mismatch flagged", s, 8'h03);
         rd_reg(0, s);
         wr_cmd(8'h05);
         rd_reg(1, s);
         chk(s[1] == 0, "R10 error reset clears parity", s, 0);
      end

      // R9/R10: overrun
      send_char(8'h11, 0);
      send_char(8'h22, 0);
      rd_reg(1, s);
      chk(s[2] == 1 && s[0] == 1, "R9 overrun set", s, 8'h05);
      rd_reg(0, s);
      chk(s == 8'h22, "R9 newer character kept", s, 8'h22);
      send_char(8'h33, 0);
      rd_reg(0, s);
      rd_reg(1, s);
      chk(s[2] == 1, "R9 overrun sticky", s, 8'h04);
      wr_cmd(8'h05);
      rd_reg(1, s);
      chk(s[2] == 0, "R10 error reset clears overrun", s, 0);

      // R12: data read in the completion cycle
      cfg_par_en = 1'b0;
      a = 8'h96; b = 8'h4B;
      send_char(a, 0);
      for (int i = 0; i < 7; i++) send_bit(b[i]);
      rxd = b[7]; @(negedge clk);
      rxc = 1'b1; cd = 1'b0; rd = 1'b1; #1 s = dout;
      @(negedge clk); rxc = 1'b0; rd = 1'b0; @(negedge clk);
      chk(s == a, "R12 collision read returns older", s, a);
      chk(rxrdy == 1, "R12 rxrdy kept", rxrdy, 1);
      rd_reg(1, s);
      chk(s[2] == 0, "R12 no overrun", s, 0);
      rd_reg(0, s);
      chk(s == b, "R12 newer character delivered", s, b);

      // R5: external sync
      cfg_ext_sync = 1'b1;
      wr_cmd(8'h03);
      send_char(cfg_sync1, 0);
      rd_reg(1, s);
      chk(s[3] == 0 && rxrdy == 0, "R5 pattern ignored in external mode", s, 0);
      syndet_in = 1'b1; send_bit(1'b1); syndet_in = 1'b0;
      chk(syndet_out == 0, "R5 pin stays low", syndet_out, 0);
      send_char(8'hC3, 0);
      rd_reg(1, s);
      chk(s == 8'h09, "R5 status after external sync", s, 8'h09);
      rd_reg(0, s);
      chk(s == 8'hC3, "R5 first character after external sync", s, 8'hC3);

      finish_run();
   end
endmodule